// File: doc/BRIEF.md
# Line-Table Bitmap Display Fetch Engine

This block fetches a one-bit-per-pixel bitmap from a 128 KB memory region and turns it into a serial pixel stream. The picture is 256 rows of 720 pixels. Each row does not follow the previous one in memory. Instead, a 16-bit entry in a relocatable 512-byte line table gives the row's start address. The row's 90 bytes are then read eight bytes apart, so eight consecutive rows can share one block of memory byte by byte. The block takes a frame pulse and a line pulse from external timing logic. For every monitor line that falls inside the active window, it reads the table entry, then streams the row's bytes out most significant bit first.

Three control registers are written through a small write port. They set the table location, a vertical position that moves the first table row down the monitor, and a mode byte that holds reverse video and screen enable. The memory read port issues a request with an address and takes the data one cycle later. Arbitration with other memory users is outside the block.

The fetch state machine has the following states and transitions:
- `ST_IDLE` goes to `ST_TAB_LO` when an accepted line pulse arrives.
- `ST_TAB_LO` and `ST_TAB_HI` issue the two table reads.
- `ST_ENTRY` decodes the entry.
- `ST_FETCH0` issues the first data read.
- `ST_LOAD` loads the first byte into the shifter.
- `ST_SHOW` shifts out 720 pixels, prefetching each next byte at bit 6, and returns to `ST_IDLE` after bit 7 of the 90th byte.

Top module: `linetab_video_gen`

## Requirements
- R1: After reset, `pix_blank` is 1, `pix_out` is 0 and `mem_req` is 0. The table base, the vertical position and both mode bits reset to zero, so the screen is disabled.
- R2: A write with `cfg_we` high loads one register, chosen by `cfg_sel`:
  - code 0 loads the table base from `cfg_data`.
  - code 1 loads the vertical position from `cfg_data`.
  - code 2 loads the mode: bit 7 sets reverse video and bit 6 sets screen enable.
  - code 3 changes nothing.
- R3: `frame_start` sets the monitor line index to 0. Each `line_start` takes the current index and then advances it, saturating at 1023.
  - A line with index i is active when 0 <= i - vpos <= 255, and it shows table row r = i - vpos.
  - An inactive line issues no memory request and keeps `pix_blank` high.
- R4: If `line_start` is sampled high at clock edge E, the row's table entry is read at address {base[7:1], 0, r[7:0], 0}, low byte first.
  - The low-byte read is requested in the cycle after E.
  - The high-byte read is requested at that address + 1 in the next cycle.
  - Bit 0 of the table base register has no effect.
- R5: An entry e gives the row start address {e[15:3], 0, e[2:0]}. The first data read for the row is requested at that address in the cycle starting at E+3.
- R6: A row makes exactly 90 data reads. Byte k comes from start + 8k, taken modulo 2^17.
- R7: Pixel p of the row is bit 7 - (p mod 8) of byte p/8.
  - Pixel 0 appears in the cycle starting at edge E+5.
  - The 720 pixels occupy consecutive cycles.
  - `pix_blank` is 1 in the cycle before the first pixel and in the cycle after the last.
- R8: With reverse video set and the screen enabled, every shown pixel is the inverse of its memory bit.
- R9: With the screen disabled, `pix_blank` stays 1 and `pix_out` stays 0, while the table and data reads still take place.
- R10: A `line_start` that arrives while a row is still being fetched or shown does not disturb that row. It still advances the line index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_sel | input | 2 | Register select: 0 table base, 1 vertical position, 2 mode, 3 none |
| cfg_data | input | 8 | Control write data |
| frame_start | input | 1 | Start-of-frame pulse, clears the line index |
| line_start | input | 1 | Start-of-line pulse |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 17 | Memory byte address |
| mem_data | input | 8 | Read data, valid the cycle after the request |
| pix_out | output | 1 | Serial pixel |
| pix_blank | output | 1 | High when no picture pixel is being shown |

## Verification
The hardest case to reach from the ports is table row 255 followed by the first inactive line. With the vertical position at 0, getting there normally takes 255 full lines of about 730 cycles each. The stimulus reaches it quickly by sending 255 closely spaced line pulses. The first pulse starts a row, and the others arrive while that row is busy. They only advance the index, which also exercises R10. The bench then checks that row 255 is fetched and shown in full and that the following line stays dark. Entries pointing near the top of memory force the stride addresses to wrap.

// File: rtl/vlt_pkg.sv
package vlt_pkg;

    localparam int VLT_ADDR_W = 17;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TAB_LO,
        ST_TAB_HI,
        ST_ENTRY,
        ST_FETCH0,
        ST_LOAD,
        ST_SHOW
    } fetch_state_t;

    localparam logic [1:0] SEL_TABLE = 2'd0;
    localparam logic [1:0] SEL_VPOS  = 2'd1;
    localparam logic [1:0] SEL_MODE  = 2'd2;

endpackage

// File: rtl/vlt_cfg_regs.sv
module vlt_cfg_regs #(
    parameter int TB_W   = 7,
    parameter int VPOS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [7:0]        cfg_data,
    output logic [TB_W-1:0]   tbase_o,
    output logic [VPOS_W-1:0] vpos_o,
    output logic              rev_o,
    output logic              en_o
);
    import vlt_pkg::*;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbase_o <= '0;
            vpos_o  <= '0;
            rev_o   <= 1'b0;
            en_o    <= 1'b0;
        end else if (cfg_we) begin
            case (cfg_sel)
                SEL_TABLE: tbase_o <= cfg_data[7 -: TB_W];
                SEL_VPOS:  vpos_o  <= cfg_data[VPOS_W-1:0];
                SEL_MODE: begin
                    rev_o <= cfg_data[7];
                    en_o  <= cfg_data[6];
                end
                default: ;
            endcase
        end
    end

    AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_sel == SEL_MODE |=> rev_o == $past(cfg_data[7]) && en_o == $past(cfg_data[6])); // R2
    AST_SPARE_SEL_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_sel == 2'd3 |=> $stable(tbase_o) && $stable(vpos_o) && $stable(rev_o) && $stable(en_o)); // R2

endmodule

// File: rtl/vlt_line_track.sv
module vlt_line_track #(
    parameter int ROWS   = 256,
    parameter int CNT_W  = 10,
    parameter int VPOS_W = 8,
    parameter int ROW_W  = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              line_start,
    input  logic [VPOS_W-1:0] vpos,
    output logic              line_go,
    output logic [ROW_W-1:0]  row
);
    localparam int DIFF_W = CNT_W + 1;

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  idx;
    logic [DIFF_W-1:0] diff;
    logic              in_window;

    assign idx       = frame_start ? '0 : cnt_q;
    assign diff      = {1'b0, idx} - {{(DIFF_W-VPOS_W){1'b0}}, vpos};
    assign in_window = !diff[DIFF_W-1] && (diff < DIFF_W'(ROWS));
    assign line_go   = line_start && in_window;
    assign row       = diff[ROW_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (frame_start) begin
            cnt_q <= line_start ? CNT_W'(1) : '0;
        end else if (line_start && cnt_q != '1) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/vlt_fetch_fsm.sv
module vlt_fetch_fsm #(
    parameter int ROW_W  = 8,
    parameter int BYTES  = 90,
    parameter int STRIDE = 8,
    parameter int ADDR_W = vlt_pkg::VLT_ADDR_W,
    parameter int TB_W   = ADDR_W - ROW_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_go,
    input  logic [ROW_W-1:0]  row,
    input  logic [TB_W-1:0]   tbase,
    input  logic              rev,
    input  logic              en,
    input  logic [7:0]        mem_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              pix_out,
    output logic              pix_blank
);
    import vlt_pkg::*;

    localparam int BYTE_W = $clog2(BYTES + 1);

    fetch_state_t      cur_q, nxt;
    logic [ROW_W-1:0]  row_q;
    logic [7:0]        ent_lo_q;
    logic [ADDR_W-1:0] fetch_addr_q;
    logic [7:0]        shreg_q;
    logic [2:0]        bit_q;
    logic [BYTE_W-1:0] byte_q;
    logic [ADDR_W-1:0] tab_addr;
    logic              more_bytes;
    logic              prefetch;

    assign tab_addr   = {tbase, 1'b0, row_q, 1'b0};
    assign more_bytes = byte_q < BYTE_W'(BYTES);
    assign prefetch   = (cur_q == ST_SHOW) && (bit_q == 3'd6) && more_bytes;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= ST_IDLE;
        else        cur_q <= nxt;
    end

    always_comb begin
        nxt = cur_q;
        unique case (cur_q)
            ST_IDLE:   if (line_go) nxt = ST_TAB_LO;
            ST_TAB_LO: nxt = ST_TAB_HI;
            ST_TAB_HI: nxt = ST_ENTRY;
            ST_ENTRY:  nxt = ST_FETCH0;
            ST_FETCH0: nxt = ST_LOAD;
            ST_LOAD:   nxt = ST_SHOW;
            ST_SHOW:   if (bit_q == 3'd7 && !more_bytes) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q        <= '0;
            ent_lo_q     <= '0;
            fetch_addr_q <= '0;
            shreg_q      <= '0;
            bit_q        <= '0;
            byte_q       <= '0;
        end else begin
            unique case (cur_q)
                ST_IDLE:   if (line_go) row_q <= row;
                ST_TAB_HI: ent_lo_q <= mem_data;
                ST_ENTRY:  fetch_addr_q <= {mem_data, ent_lo_q[7:3], 1'b0, ent_lo_q[2:0]};
                ST_FETCH0: fetch_addr_q <= fetch_addr_q + ADDR_W'(STRIDE);
                ST_LOAD: begin
                    shreg_q <= mem_data;
                    bit_q   <= 3'd0;
                    byte_q  <= BYTE_W'(1);
                end
                ST_SHOW: begin
                    bit_q <= bit_q + 3'd1;
                    if (bit_q == 3'd7) begin
                        shreg_q <= mem_data;
                        if (more_bytes) byte_q <= byte_q + 1'b1;
                    end else begin
                        shreg_q <= {shreg_q[6:0], 1'b0};
                    end
                    if (prefetch) fetch_addr_q <= fetch_addr_q + ADDR_W'(STRIDE);
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_addr  = fetch_addr_q;
        pix_out   = 1'b0;
        pix_blank = 1'b1;
        unique case (cur_q)
            ST_TAB_LO: begin mem_req = 1'b1; mem_addr = tab_addr; end
            ST_TAB_HI: begin mem_req = 1'b1; mem_addr = tab_addr | ADDR_W'(1); end
            ST_FETCH0: mem_req = 1'b1;
            ST_SHOW: begin
                mem_req   = prefetch;
                pix_blank = !en;
                pix_out   = en && (shreg_q[7] ^ rev);
            end
            default: ;
        endcase
    end

    AST_TABLE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q == ST_TAB_LO |=> mem_req && mem_addr == $past(mem_addr) + ADDR_W'(1)); // R4
    AST_STRIDE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && cur_q == ST_SHOW |-> mem_addr == $past(mem_addr, 8) + ADDR_W'(STRIDE)); // R6
    AST_BYTE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        byte_q <= BYTE_W'(BYTES)); // R6
    AST_SHOW_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q == ST_LOAD |=> cur_q == ST_SHOW && bit_q == 3'd0 && byte_q == BYTE_W'(1)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q == ST_IDLE |-> !mem_req && pix_blank && !pix_out); // R3
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q == ST_SHOW && bit_q != 3'd7 |=> cur_q == ST_SHOW); // R10

endmodule

// File: rtl/linetab_video_gen.sv
module linetab_video_gen #(
    parameter int ROWS   = 256,
    parameter int BYTES  = 90,
    parameter int STRIDE = 8,
    parameter int CNT_W  = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [7:0]  cfg_data,
    input  logic        frame_start,
    input  logic        line_start,
    output logic        mem_req,
    output logic [16:0] mem_addr,
    input  logic [7:0]  mem_data,
    output logic        pix_out,
    output logic        pix_blank
);
    localparam int ADDR_W = vlt_pkg::VLT_ADDR_W;
    localparam int ROW_W  = $clog2(ROWS);
    localparam int VPOS_W = 8;
    localparam int TB_W   = ADDR_W - ROW_W - 2;

    logic [TB_W-1:0]   tbase;
    logic [VPOS_W-1:0] vpos;
    logic              rev, en, line_go;
    logic [ROW_W-1:0]  row;

    vlt_cfg_regs #(.TB_W(TB_W), .VPOS_W(VPOS_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .tbase_o(tbase), .vpos_o(vpos), .rev_o(rev), .en_o(en)
    );

    vlt_line_track #(.ROWS(ROWS), .CNT_W(CNT_W), .VPOS_W(VPOS_W), .ROW_W(ROW_W)) u_track (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
        .vpos(vpos), .line_go(line_go), .row(row)
    );

    vlt_fetch_fsm #(.ROW_W(ROW_W), .BYTES(BYTES), .STRIDE(STRIDE), .ADDR_W(ADDR_W), .TB_W(TB_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .line_go(line_go), .row(row), .tbase(tbase), .rev(rev), .en(en),
        .mem_data(mem_data), .mem_req(mem_req), .mem_addr(mem_addr),
        .pix_out(pix_out), .pix_blank(pix_blank)
    );

endmodule

// File: tb/test_linetab_video_gen.sv
module test_linetab_video_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [7:0]  cfg_data = 8'd0;
    logic        frame_start = 1'b0;
    logic        line_start = 1'b0;
    logic        mem_req;
    logic [16:0] mem_addr;
    logic [7:0]  mem_data = 8'd0;
    logic        pix_out, pix_blank;

    int n_chk = 0;
    int n_bad = 0;

    logic [15:0] tab [0:255];
    logic [7:0]  salt = 8'h5A;
    logic [6:0]  tb_m = 7'd0;
    logic [7:0]  vpos_m = 8'd0;
    logic        rev_m = 1'b0;
    logic        en_m = 1'b0;
    int          idx_m = 0;

    always #4 clk = ~clk;

    linetab_video_gen i_linetab_video_gen (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .frame_start(frame_start), .line_start(line_start), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_data(mem_data), .pix_out(pix_out), .pix_blank(pix_blank)
    );

    function automatic logic [7:0] mem_model(input logic [16:0] a);
        logic [15:0] e;
        if (a[16:10] == tb_m && !a[9]) begin
            e = tab[a[8:1]];
            return a[0] ? e[15:8] : e[7:0];
        end
        return (a[7:0] * 8'd29) ^ a[15:8] ^ {a[16], 7'd0} ^ salt;
    endfunction

    always @(posedge clk) if (mem_req) mem_data <= mem_model(mem_addr);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
        @(negedge clk); cfg_we = 1'b0;
        case (sel)
            2'd0: tb_m = d[7:1];
            2'd1: vpos_m = d;
            2'd2: begin rev_m = d[7]; en_m = d[6]; end
            default: ;
        endcase
    endtask

    task automatic new_frame();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        idx_m = 0;
    endtask

    task automatic run_line();
        int          r;
        bit          act;
        logic [16:0] base, ta;
        logic [7:0]  lb [0:89];
        int          bad_p;
        logic        ep, eb;
        r   = idx_m - int'(vpos_m);
        act = (r >= 0) && (r <= 255);
        idx_m++;
        @(negedge clk); line_start = 1'b1;
        @(negedge clk); line_start = 1'b0;
        if (!act) begin
            bad_p = -1;
            for (int c = 0; c < 730; c++) begin
                if ((mem_req || !pix_blank || pix_out) && bad_p < 0) bad_p = c;
                @(negedge clk);
            end
            check(bad_p < 0, "R3 inactive line quiet", bad_p, -1);
            return;
        end
        ta   = {tb_m, 1'b0, 8'(r), 1'b0};
        base = {tab[r][15:3], 1'b0, tab[r][2:0]};
        for (int k = 0; k < 90; k++) lb[k] = mem_model(base + 17'(8 * k));
        check(mem_req && mem_addr == ta, "R4 table low-byte read", int'(mem_addr), int'(ta));
        @(negedge clk);
        check(mem_req && mem_addr == (ta | 17'd1), "R4 table high-byte read", int'(mem_addr), int'(ta | 17'd1));
        repeat (2) @(negedge clk);
        check(mem_req && mem_addr == base, "R5 first data read", int'(mem_addr), int'(base));
        @(negedge clk);
        check(pix_blank == 1'b1, "R7 blank before first pixel", int'(pix_blank), 1);
        @(negedge clk);
        bad_p = -1;
        ep = 1'b0;
        eb = 1'b0;
        for (int p = 0; p < 720; p++) begin
            logic xp, xb;
            xb = !en_m;
            xp = en_m && (lb[p / 8][7 - (p % 8)] ^ rev_m);
            if ((pix_out !== xp || pix_blank !== xb) && bad_p < 0) begin
                bad_p = p; ep = xp; eb = xb;
                $display("  row %0d pixel %0d: out=%0b blank=%0b want out=%0b blank=%0b",
                         r, p, pix_out, pix_blank, xp, xb);
            end
            @(negedge clk);
        end
        check(bad_p < 0, en_m ? (rev_m ? "R8 R6 R7 reversed pixel stream" : "R6 R7 pixel stream")
                              : "R9 disabled screen stays dark", bad_p, -1);
        check(pix_blank == 1'b1 && !mem_req, "R7 blank after last pixel", int'(pix_blank), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        for (int i = 0; i < 256; i++) tab[i] = 16'($urandom);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(pix_blank == 1'b1 && pix_out == 1'b0 && mem_req == 1'b0, "R1 reset outputs",
              {pix_blank, pix_out, mem_req}, 3'b100);

        // R1: mode resets to disabled, so a line shows nothing
        new_frame();
        run_line();

        write_cfg(2'd0, 8'h46);
        write_cfg(2'd2, 8'h40);
        new_frame();
        tab[2] = 16'h000F;              // R5 offset 7, bit 3 forced to zero
        run_line(); run_line(); run_line();

        write_cfg(2'd2, 8'hC0);         // R8
        run_line();

        write_cfg(2'd2, 8'h80);         // R9 disabled with reverse set
        run_line();

        write_cfg(2'd2, 8'h40);
        write_cfg(2'd3, 8'hFF);         // R2 spare select
        write_cfg(2'd0, 8'h47);         // R4 bit 0 ignored
        tab[6] = 16'hFFFF;              // R6 wrap at top of memory
        run_line(); run_line();

        // R3 vertical position
        write_cfg(2'd1, 8'd3);
        new_frame();
        run_line(); run_line(); run_line();
        run_line(); run_line();

        // R3 R10 last row and first line past the window
        write_cfg(2'd1, 8'd0);
        new_frame();
        for (int i = 0; i < 255; i++) begin
            @(negedge clk); line_start = 1'b1;
            @(negedge clk); line_start = 1'b0;
            idx_m++;
        end
        repeat (400) @(negedge clk);
        check(pix_blank && !mem_req, "R10 busy pulses ended cleanly", int'(pix_blank), 1);
        run_line();
        run_line();

        // random lines
        for (int n = 0; n < 8; n++) begin
            logic [7:0] m;
            salt = 8'($urandom);
            write_cfg(2'd0, 8'($urandom));
            m = 8'($urandom);
            m[6] = m[6] | (n < 6);
            write_cfg(2'd2, m);
            write_cfg(2'd1, 8'($urandom_range(0, 2)));
            new_frame();
            for (int i = 0; i < 256; i++) if ($urandom_range(0, 3) == 0) tab[i] = 16'($urandom);
            run_line(); run_line(); run_line();
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule